// File: doc/BRIEF.md
# Launch Key Hash Register Guard

This block is a small bank of configuration registers behind a single-cycle address/data port. Four 64-bit registers together hold a 256-bit digest of the root signing key. A feature-control register and an activation register sit beside them. The block decides, request by request, whether a write to a digest register is allowed. The rule depends on three things: whether the platform has been activated, whether the launch-control bit is set, and whether the feature-control register is locked.

During early boot, before activation, firmware may overwrite the digest freely, for example to install its own key. After activation the digest is writable only when both the launch-control bit and the lock bit are 1, which lets firmware hand control of the key to the operating system. Firmware can instead freeze the key by locking with launch-control left at 0. A disallowed write, a write to a locked feature-control register and any access to an address outside the map all raise a one-cycle fault and change nothing.

Address map (12-bit word addresses): digest registers 0..3 at 0x08C..0x08F, feature control at 0x03A, activation at 0x07A.

Top module: `keyhash_guard`

## Requirements
- R1: After reset, digest register n holds bits [64n+63:64n] of the configured 256-bit default, and the feature-control and activation registers read 0.
- R2: While activation is 0, a write to any digest register (0x08C..0x08F) stores its data and raises no fault.
- R3: A write to 0x07A with data bit 0 = 1 sets the activation flag, which then reads back as bit 0 of 0x07A. A write with bit 0 = 0 does not change it, and only reset clears it.
- R4: While activation is 1, a digest write is stored if and only if feature-control bit 17 (launch control) and bit 0 (lock) are both 1. Otherwise it faults and leaves the digest unchanged.
- R5: While activation is 0, feature-control bits 17 and 18 always store 0 whatever the written value. The other bits store as written. After activation, bits 17 and 18 store as written.
- R6: Once feature-control bit 0 (lock) is 1, every write to feature control faults and leaves its value unchanged until reset.
- R7: A read returns the current register contents on rsp_rdata in the cycle after the request. The fault for a request also appears in the cycle after it.
- R8: A read or write to an address outside the map faults, and a read there returns 0.
- R9: fault is high for exactly the one cycle after each rejected request, and low after every accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, valid the cycle after a read |
| fault | output | 1 | One-cycle pulse for a rejected request |

## Verification
Any corrupt permission state shows up at the ports on the very next digest access. A wrongly set activation or lock flag makes an allowed write fault, or lets a forbidden write land, and the following readback exposes it one cycle later. A gating slip in feature control shows as bits 17 or 18 reading back as 1 before activation. A decode error shows during the sweep of the low 256 addresses, as nonzero read data or a missing fault at an unmapped address.

// File: rtl/keyhash_pkg.sv
`timescale 1ns/1ps
package keyhash_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_HASH = 2'd1,
      SEL_FC   = 2'd2,
      SEL_ACT  = 2'd3
   } kh_sel_e;
endpackage

// File: rtl/keyhash_decode.sv
`timescale 1ns/1ps
module keyhash_decode
   import keyhash_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int HASH_REGS = 4,
   parameter int IDX_W     = 2,
   parameter logic [ADDR_W-1:0] HASH_BASE = 12'h08C,
   parameter logic [ADDR_W-1:0] FC_ADDR   = 12'h03A,
   parameter logic [ADDR_W-1:0] ACT_ADDR  = 12'h07A
) (
   input  logic [ADDR_W-1:0] addr,
   output kh_sel_e           sel,
   output logic [IDX_W-1:0]  idx
);
   logic [HASH_REGS-1:0] hit;

   genvar g;
   generate
      for (g = 0; g < HASH_REGS; g++) begin : g_hit
         assign hit[g] = (addr == HASH_BASE + ADDR_W'(g));
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < HASH_REGS; i++) begin
         if (hit[i]) idx = IDX_W'(i);
      end
      if (|hit)                 sel = SEL_HASH;
      else if (addr == FC_ADDR) sel = SEL_FC;
      else if (addr == ACT_ADDR) sel = SEL_ACT;
      else                      sel = SEL_NONE;
   end
endmodule

// File: rtl/keyhash_ctrl.sv
`timescale 1ns/1ps
module keyhash_ctrl #(
   parameter int DATA_W   = 64,
   parameter int LC_BIT   = 17,
   parameter int LOCK_BIT = 0,
   parameter logic [DATA_W-1:0] GATED_MASK = 64'h0000_0000_0006_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fc,
   input  logic              wr_act,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] fc_q,
   output logic              act_q,
   output logic              fc_reject,
   output logic              hash_wr_ok
);
   logic              locked;
   logic [DATA_W-1:0] fc_next;

   assign locked     = fc_q[LOCK_BIT];
   assign fc_reject  = wr_fc & locked;
   assign hash_wr_ok = ~act_q | (fc_q[LC_BIT] & locked);
   assign fc_next    = act_q ? wdata : (wdata & ~GATED_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fc_q  <= '0;
         act_q <= 1'b0;
      end else begin
         if (wr_fc && !locked) fc_q <= fc_next;
         if (wr_act && wdata[0]) act_q <= 1'b1;
      end
   end
endmodule

// File: rtl/keyhash_bank.sv
`timescale 1ns/1ps
module keyhash_bank #(
   parameter int DATA_W    = 64,
   parameter int HASH_REGS = 4,
   parameter int IDX_W     = 2,
   parameter logic [HASH_REGS*DATA_W-1:0] DEFAULT_HASH = '0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [IDX_W-1:0]                    idx,
   input  logic [DATA_W-1:0]                   wdata,
   output logic [HASH_REGS-1:0][DATA_W-1:0]    hash_q
);
   genvar g;
   generate
      for (g = 0; g < HASH_REGS; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               hash_q[g] <= DEFAULT_HASH[g*DATA_W +: DATA_W];
            else if (we && idx == IDX_W'(g))
               hash_q[g] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/keyhash_guard.sv
`timescale 1ns/1ps
module keyhash_guard
   import keyhash_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 64,
   parameter int HASH_REGS = 4,
   parameter int LC_BIT    = 17,
   parameter int LOCK_BIT  = 0,
   parameter logic [ADDR_W-1:0] HASH_BASE = 12'h08C,
   parameter logic [ADDR_W-1:0] FC_ADDR   = 12'h03A,
   parameter logic [ADDR_W-1:0] ACT_ADDR  = 12'h07A,
   parameter logic [DATA_W-1:0] GATED_MASK = 64'h0000_0000_0006_0000,
   parameter logic [HASH_REGS*DATA_W-1:0] DEFAULT_HASH =
      256'h5d1e_0c44_9ab3_71f2_e806_2b9d_44c7_a031_9f0e_6d28_b7c1_5a43_0e92_f6b8_3c7d_1a55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              fault
);
   localparam int IDX_W = (HASH_REGS > 1) ? $clog2(HASH_REGS) : 1;

   generate
      if (DATA_W <= LC_BIT || DATA_W <= LOCK_BIT)
         $error("keyhash_guard: DATA_W too narrow for control bits");
      if (HASH_REGS < 1)
         $error("keyhash_guard: HASH_REGS must be at least 1");
      if (LC_BIT == LOCK_BIT)
         $error("keyhash_guard: launch-control and lock bits must differ");
   endgenerate

   kh_sel_e                         sel;
   logic [IDX_W-1:0]                idx;
   logic [DATA_W-1:0]               fc_q;
   logic                            act_q;
   logic                            fc_reject;
   logic                            hash_wr_ok;
   logic [HASH_REGS-1:0][DATA_W-1:0] hash_q;
   logic                            dec_miss;
   logic                            wr_req;
   logic                            hash_we;
   logic                            reject;
   logic [DATA_W-1:0]               rd_mux;

   keyhash_decode #(
      .ADDR_W(ADDR_W), .HASH_REGS(HASH_REGS), .IDX_W(IDX_W),
      .HASH_BASE(HASH_BASE), .FC_ADDR(FC_ADDR), .ACT_ADDR(ACT_ADDR)
   ) u_dec (
      .addr(req_addr), .sel(sel), .idx(idx)
   );

   assign dec_miss = (sel == SEL_NONE);
   assign wr_req   = req_valid & req_write;

   keyhash_ctrl #(
      .DATA_W(DATA_W), .LC_BIT(LC_BIT), .LOCK_BIT(LOCK_BIT), .GATED_MASK(GATED_MASK)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_fc(wr_req && sel == SEL_FC),
      .wr_act(wr_req && sel == SEL_ACT),
      .wdata(req_wdata),
      .fc_q(fc_q), .act_q(act_q),
      .fc_reject(fc_reject), .hash_wr_ok(hash_wr_ok)
   );

   assign hash_we = wr_req && sel == SEL_HASH && hash_wr_ok;

   keyhash_bank #(
      .DATA_W(DATA_W), .HASH_REGS(HASH_REGS), .IDX_W(IDX_W),
      .DEFAULT_HASH(DEFAULT_HASH)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .we(hash_we), .idx(idx),
      .wdata(req_wdata), .hash_q(hash_q)
   );

   always_comb begin
      reject = dec_miss;
      if (req_write && sel == SEL_HASH && !hash_wr_ok) reject = 1'b1;
      if (req_write && fc_reject)                      reject = 1'b1;
   end

   always_comb begin
      unique case (sel)
         SEL_HASH: rd_mux = hash_q[idx];
         SEL_FC:   rd_mux = fc_q;
         SEL_ACT:  rd_mux = {{(DATA_W-1){1'b0}}, act_q};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         fault     <= 1'b0;
      end else begin
         fault <= req_valid & reject;
         if (req_valid && !req_write) rsp_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/keyhash_guard_chk.sv
`timescale 1ns/1ps
module keyhash_guard_chk #(
   parameter int DATA_W    = 64,
   parameter int HASH_REGS = 4,
   parameter int LC_BIT    = 17,
   parameter int LOCK_BIT  = 0,
   parameter logic [DATA_W-1:0] GATED_MASK = 64'h0000_0000_0006_0000
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_valid,
   input logic                             dec_miss,
   input logic                             fault,
   input logic                             act,
   input logic [DATA_W-1:0]                fc,
   input logic [HASH_REGS-1:0][DATA_W-1:0] hash
);
   // R3: activation never drops without reset
   a_r3_act_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> act);

   // R4: after activation without launch control and lock, digest is frozen
   a_r4_hash_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !(fc[LC_BIT] && fc[LOCK_BIT])) |=> $stable(hash));

   // R5: gated feature bits stay 0 before activation
   a_r5_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> ((fc & GATED_MASK) == '0));

   // R6: locked feature control keeps its value
   a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fc[LOCK_BIT] |=> (fc[LOCK_BIT] && $stable(fc)));

   // R8: unmapped access faults in the next cycle
   a_r8_miss_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && dec_miss) |=> fault);

   // R9: a fault always follows a request
   a_r9_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_valid));
endmodule

bind keyhash_guard keyhash_guard_chk #(
   .DATA_W(DATA_W), .HASH_REGS(HASH_REGS), .LC_BIT(LC_BIT),
   .LOCK_BIT(LOCK_BIT), .GATED_MASK(GATED_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .dec_miss(dec_miss),
   .fault(fault), .act(act_q), .fc(fc_q), .hash(hash_q)
);

// File: tb/keyhash_guard_bench.sv
`timescale 1ns/1ps
module keyhash_guard_bench;
   localparam logic [255:0] DEF =
      256'h1111_2222_3333_4444_5555_6666_7777_8888_9999_aaaa_bbbb_cccc_dddd_eeee_ffff_0123;
   localparam logic [11:0] HB  = 12'h08C;
   localparam logic [11:0] FCA = 12'h03A;
   localparam logic [11:0] ACA = 12'h07A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic [63:0] rsp_rdata;
   logic        fault;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [63:0] exp_hash [4];

   always #2 clk = ~clk;

   keyhash_guard #(.DEFAULT_HASH(DEF)) u_keyhash_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .fault(fault)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) exp_hash[i] = DEF[i*64 +: 64];
   endtask

   // one request; results sampled the cycle after; fault must be gone one cycle later
   task automatic access(input string req, input logic w, input logic [11:0] a,
                         input logic [63:0] d, output logic [63:0] rd, output logic f);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      rd = rsp_rdata; f = fault;
      req_valid = 1'b0; req_write = 1'b0;
      @(negedge clk);
      chk({req, " R9 pulse ends"}, {63'b0, fault}, 64'd0);
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
      logic [63:0] rd; logic f;
      access(req, 1'b0, a, '0, rd, f);
      chk({req, " R7 data"}, rd, exp);
      chk({req, " R7 no fault"}, {63'b0, f}, 64'd0);
   endtask

   task automatic wr_chk(input string req, input logic [11:0] a, input logic [63:0] d,
                         input logic exp_f);
      logic [63:0] rd; logic f;
      access(req, 1'b1, a, d, rd, f);
      chk({req, " R9 fault"}, {63'b0, f}, {63'b0, exp_f});
   endtask

   task automatic hash_all(input string req);
      for (int i = 0; i < 4; i++) rd_chk(req, HB + 12'(i), exp_hash[i]);
   endtask

   initial begin
      logic [63:0] rd; logic f;
      do_reset();

      // R1 reset state
      hash_all("R1 default digest");
      rd_chk("R1 fc zero", FCA, 64'd0);
      rd_chk("R1 act zero", ACA, 64'd0);

      // R2 free writes before activation
      for (int i = 0; i < 4; i++) begin
         exp_hash[i] = 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101);
         wr_chk("R2 pre-act write", HB + 12'(i), exp_hash[i], 1'b0);
      end
      hash_all("R2 readback");

      // R5 gated bits before activation
      wr_chk("R5 fc write pre-act", FCA, 64'h0000_0000_0006_0006, 1'b0);
      rd_chk("R5 gated bits cleared", FCA, 64'h6);

      // R3 activation
      wr_chk("R3 act write 0", ACA, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
      rd_chk("R3 act still 0", ACA, 64'd0);
      wr_chk("R3 act set", ACA, 64'd1, 1'b0);
      rd_chk("R3 act is 1", ACA, 64'd1);
      wr_chk("R3 act write 0 after", ACA, 64'd0, 1'b0);
      rd_chk("R3 act sticky", ACA, 64'd1);

      // R4 no launch control, no lock
      wr_chk("R4 reject lc0 lock0", HB + 12'd2, 64'hDEAD_BEEF_0000_0001, 1'b1);
      hash_all("R4 unchanged a");

      // R5 gated bits settable after activation; R4 lc without lock
      wr_chk("R5 fc lc only", FCA, 64'h0000_0000_0002_0000, 1'b0);
      rd_chk("R5 lc stored", FCA, 64'h0000_0000_0002_0000);
      wr_chk("R4 reject lc1 lock0", HB, 64'hDEAD_BEEF_0000_0002, 1'b1);
      hash_all("R4 unchanged b");

      // R4 lc and lock -> writable
      wr_chk("R6 set lock", FCA, 64'h0000_0000_0002_0001, 1'b0);
      rd_chk("R6 lock stored", FCA, 64'h0000_0000_0002_0001);
      for (int i = 0; i < 4; i++) begin
         exp_hash[i] = 64'h0BAD_F00D_0000_0000 + 64'(i);
         wr_chk("R4 accept lc1 lock1", HB + 12'(i), exp_hash[i], 1'b0);
      end
      hash_all("R4 readback");

      // R6 locked fc rejects writes
      wr_chk("R6 fc write locked", FCA, 64'd0, 1'b1);
      rd_chk("R6 fc unchanged", FCA, 64'h0000_0000_0002_0001);

      // second run: freeze key by locking without launch control
      do_reset();
      exp_hash[3] = 64'h1234_5678_9ABC_DEF0;
      wr_chk("R2 pre-act write 3", HB + 12'd3, exp_hash[3], 1'b0);
      wr_chk("R3 act set run2", ACA, 64'd1, 1'b0);
      wr_chk("R6 lock without lc", FCA, 64'd1, 1'b0);
      for (int i = 0; i < 4; i++)
         wr_chk("R4 frozen reject", HB + 12'(i), 64'hFFFF_0000_FFFF_0000, 1'b1);
      hash_all("R4 frozen readback");
      wr_chk("R6 lc after lock", FCA, 64'h0000_0000_0002_0001, 1'b1);
      rd_chk("R6 fc still lock only", FCA, 64'd1);

      // R8 sweep of low 256 addresses
      for (int a = 0; a < 256; a++) begin
         logic mapped;
         logic [63:0] exp;
         mapped = (a >= 'h8C && a <= 'h8F) || a == 'h3A || a == 'h7A;
         exp = 64'd0;
         if (a >= 'h8C && a <= 'h8F) exp = exp_hash[a - 'h8C];
         else if (a == 'h3A) exp = 64'd1;
         else if (a == 'h7A) exp = 64'd1;
         access("R8 sweep", 1'b0, 12'(a), '0, rd, f);
         chk("R8 sweep data", rd, exp);
         chk("R8 sweep fault", {63'b0, f}, {63'b0, ~mapped});
      end
      wr_chk("R8 unmapped write", 12'hFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      wr_chk("R8 unmapped write near", HB + 12'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      hash_all("R8 digest intact");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule